// File: doc/BRIEF.md
# Serial Frequency Register Bank

This block is the control side of an integer-N synthesizer. A three-wire serial port (data, shift clock and strobes) fills a primary frequency word, an eight-bit enhancement word and a word that can also be loaded in parallel from a non-volatile store. Three control levels pick which register the serial port shifts into. A rising transfer strobe copies the primary word into a secondary word, which gives double buffering. A falling enhancement strobe publishes the enhancement shift register to the function outputs.

A second selection, made from three further control levels, picks which of the primary, secondary or stored word drives the divider fields. The selected 20-bit word is split into a 6-bit reference divide value, a 9-bit main divide value, a 4-bit swallow count and a prescaler bypass flag. The enhancement word, gated by an active-low enable, drives power-down and immediate-load flags. It also steers one of four sources onto a single serial output: the stored word for readback, the main divider tick, the modulus select or the reference divider tick.

Every control input is asynchronous to the system clock. Each one passes through a synchronizer and an edge detector, so all storage updates on the system clock. Two state machines run the block. The port machine has states PORT_IDLE, PORT_PRI, PORT_ENH and PORT_NV. Each cycle it moves to the state that the strobe levels decode: to PORT_PRI for (0,0,0), to PORT_ENH for (0,1,0), to PORT_NV for (0,x,1), and to PORT_IDLE otherwise. The source machine has states SRC_SEC (the reset state), SRC_PRI and SRC_NV. While the store-load level is low, it moves to SRC_NV when the store-select level is high. Otherwise it moves to SRC_PRI when the word-select level is high and to SRC_SEC when it is low. While the store-load level is high, it holds its state.

Top module: `freq_reg_bank`

## Requirements
- R1: Each rising edge of `ser_clk` shifts `ser_data` into the register chosen by the port state. The new bit enters at bit 19 (bit 7 for the enhancement word) and the register shifts toward bit 0, so the first bit sent ends at bit 0.
- R2: The shift destination is decoded from (`xfer_strobe`, `enh_strobe`, `nv_load`): 0,0,0 selects the primary word, 0,1,0 selects the enhancement shift register, and 0,x,1 selects the stored word. Any other combination shifts nothing. A shift into one register leaves the others unchanged.
- R3: A rising `xfer_strobe` copies the primary word into the secondary word. The secondary word changes at no other time.
- R4: The published enhancement word changes only on a falling `enh_strobe`, when it takes the contents of the enhancement shift register.
- R5: The source selection follows (`nv_sel`, `word_sel`, `nv_load`): 0,1,0 selects the primary word, 0,0,0 selects the secondary word, and 1,x,0 selects the stored word. While `nv_load` is 1, the previous selection is held. After reset the secondary word is selected.
- R6: The primary word is unbuffered. While it is selected, every bit shifted into it appears on the field outputs at once.
- R7: The stored word loads `nv_word` in parallel on a rising `nv_sel` while `nv_load` is 0, or on a falling `nv_load` while `nv_sel` is 1. It does not load when no such edge occurs.
- R8: The field layout of the selected word w is as follows. `r_div` = {w0,w1,w12,w13,w14,w15}, `m_div` = {w2,w3,w5,w6,w7,w8,w9,w10,w11}, `bypass` = w4 and `a_div` = {w16,w17,w18,w19}. Each list is written from the most significant bit to the least significant bit.
- R9: While `enh_en_n` is 1, all enhancement functions are off. While it is 0, `pwr_down` follows published bit 3 and `cnt_load` follows published bit 4.
- R10: Published bits 1, 2, 5 and 6 route the stored word's bit 0, `div_main_tick`, `mod_sel` and `div_ref_tick` to `dout`. If more than one of these bits is set, the lowest set bit wins. If none is set, `dout` is 0. `route_err` is 1 exactly when two or more of these bits are set and the enhancement functions are enabled.
- R11: While readback is routed (bit 1 enabled), each rising `ser_clk` shifts the stored word toward bit 0 and fills it from `ser_data`. Bit 0 is visible on `dout` before the first edge, so 19 edges present all 20 bits.
- R12: After reset, the field outputs, `pwr_down`, `cnt_load`, `dout` and `route_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock |
| ser_data | input | 1 | Serial data, least significant bit first |
| xfer_strobe | input | 1 | Transfer strobe; a rising edge copies primary to secondary |
| enh_strobe | input | 1 | Enhancement strobe; a falling edge publishes the enhancement word |
| nv_load | input | 1 | Store-load level and edge |
| nv_sel | input | 1 | Store-select level and edge |
| word_sel | input | 1 | Chooses primary (1) or secondary (0) |
| enh_en_n | input | 1 | Active-low enable for the enhancement functions |
| nv_word | input | 20 | Parallel word from the non-volatile store |
| div_main_tick | input | 1 | Main divider output, routable to dout |
| div_ref_tick | input | 1 | Reference divider output, routable to dout |
| mod_sel | input | 1 | Prescaler modulus select, routable to dout |
| r_div | output | 6 | Reference divide field |
| m_div | output | 9 | Main divide field |
| a_div | output | 4 | Swallow count field |
| bypass | output | 1 | Prescaler bypass flag |
| pwr_down | output | 1 | Power-down request |
| cnt_load | output | 1 | Immediate counter load request |
| dout | output | 1 | Routed serial output |
| route_err | output | 1 | More than one output route requested |

## Verification
The hardest state to reach is a readback that shifts the stored word while the primary word shifts alongside it. Readback is only reached after a serial load of the stored word and the publication of an enhancement word. The bench therefore first fills the stored word through the 0,x,1 destination and lowers `nv_load` while `nv_sel` is low, so that no parallel load overwrites it. It then publishes bit 1 and clocks 19 edges, comparing each `dout` bit with its own shadow models of every register. All sixteen route combinations are then swept against all eight patterns of the three tick inputs.

// File: rtl/frb_pkg.sv
package frb_pkg;

    localparam int WORD_W = 20;
    localparam int ENH_W  = 8;
    localparam int R_W    = 6;
    localparam int M_W    = 9;
    localparam int A_W    = 4;

    localparam int EB_READBACK = 1;
    localparam int EB_FP       = 2;
    localparam int EB_PWRDN    = 3;
    localparam int EB_CNTLD    = 4;
    localparam int EB_MSEL     = 5;
    localparam int EB_FC       = 6;
    localparam int N_ROUTE     = 4;

    typedef enum logic [1:0] {
        PORT_IDLE,
        PORT_PRI,
        PORT_ENH,
        PORT_NV
    } port_state_t;

    typedef enum logic [1:0] {
        SRC_SEC,
        SRC_PRI,
        SRC_NV
    } src_state_t;

    typedef struct packed {
        logic [R_W-1:0] r;
        logic [M_W-1:0] m;
        logic [A_W-1:0] a;
        logic           pb;
    } freq_fields_t;

    // Scatter of the divider fields across the serial word.
    function automatic freq_fields_t split_word(input logic [WORD_W-1:0] w);
        freq_fields_t f;
        f.r  = {w[0], w[1], w[12], w[13], w[14], w[15]};
        f.m  = {w[2], w[3], w[5], w[6], w[7], w[8], w[9], w[10], w[11]};
        f.pb = w[4];
        f.a  = {w[16], w[17], w[18], w[19]};
        return f;
    endfunction

endpackage

// File: rtl/frb_sync.sv
module frb_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] pipe [STAGES+1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= async_in;
            for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign lvl  = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] & pipe[STAGES];

endmodule

// File: rtl/frb_port.sv
module frb_port
    import frb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              data_s,
    input  logic              xfer_s,
    input  logic              xfer_rise,
    input  logic              estb_s,
    input  logic              estb_fall,
    input  logic              nvld_s,
    input  logic              nv_par_load,
    input  logic              readback_on,
    input  logic [WORD_W-1:0] nv_word,
    output logic              pri_shift,
    output logic              enh_shift,
    output logic              ee_shift,
    output logic [WORD_W-1:0] pri_q,
    output logic [WORD_W-1:0] sec_q,
    output logic [ENH_W-1:0]  enh_buf,
    output logic [WORD_W-1:0] ee_q
);

    port_state_t port_q, port_d;
    logic [ENH_W-1:0] enh_sr;

    // Next destination from the strobe levels
    always_comb begin
        unique case ({xfer_s, estb_s, nvld_s})
            3'b000:         port_d = PORT_PRI;
            3'b010:         port_d = PORT_ENH;
            3'b001, 3'b011: port_d = PORT_NV;
            default:        port_d = PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) port_q <= PORT_IDLE;
        else        port_q <= port_d;
    end

    // Shift strobes from the state
    always_comb begin
        pri_shift = 1'b0;
        enh_shift = 1'b0;
        ee_shift  = sclk_rise && readback_on;
        unique case (port_q)
            PORT_PRI:  pri_shift = sclk_rise;
            PORT_ENH:  enh_shift = sclk_rise;
            PORT_NV:   ee_shift  = sclk_rise;
            PORT_IDLE: ;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pri_q   <= '0;
            sec_q   <= '0;
            enh_sr  <= '0;
            enh_buf <= '0;
            ee_q    <= '0;
        end else begin
            if (pri_shift) pri_q <= {data_s, pri_q[WORD_W-1:1]};
            if (xfer_rise) sec_q <= pri_q;
            if (enh_shift) enh_sr <= {data_s, enh_sr[ENH_W-1:1]};
            if (estb_fall) enh_buf <= enh_sr;
            if (nv_par_load)   ee_q <= nv_word;
            else if (ee_shift) ee_q <= {data_s, ee_q[WORD_W-1:1]};
        end
    end

endmodule

// File: rtl/frb_route.sv
module frb_route
    import frb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nvsel_s,
    input  logic              fsel_s,
    input  logic              nvld_s,
    input  logic              enh_n_s,
    input  logic [WORD_W-1:0] pri_q,
    input  logic [WORD_W-1:0] sec_q,
    input  logic [WORD_W-1:0] ee_q,
    input  logic [ENH_W-1:0]  enh_buf,
    input  logic              fp_tick,
    input  logic              fc_tick,
    input  logic              msel,
    output freq_fields_t      fields,
    output logic              pwr_down,
    output logic              cnt_load,
    output logic              readback_on,
    output logic              dout,
    output logic              route_err
);

    localparam int ROUTE_BIT [N_ROUTE] = '{EB_READBACK, EB_FP, EB_MSEL, EB_FC};

    src_state_t src_q, src_d;
    logic [WORD_W-1:0]  word;
    logic [ENH_W-1:0]   eff;
    logic [N_ROUTE-1:0] route_req;
    logic [N_ROUTE-1:0] route_src;

    always_comb begin
        unique casez ({nvld_s, nvsel_s, fsel_s})
            3'b1??:  src_d = src_q;
            3'b01?:  src_d = SRC_NV;
            3'b001:  src_d = SRC_PRI;
            3'b000:  src_d = SRC_SEC;
            default: src_d = src_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= SRC_SEC;
        else        src_q <= src_d;
    end

    always_comb begin
        unique case (src_q)
            SRC_PRI: word = pri_q;
            SRC_NV:  word = ee_q;
            SRC_SEC: word = sec_q;
            default: word = sec_q;
        endcase
        fields = split_word(word);
    end

    assign eff         = enh_n_s ? '0 : enh_buf;
    assign pwr_down    = eff[EB_PWRDN];
    assign cnt_load    = eff[EB_CNTLD];
    assign readback_on = eff[EB_READBACK];
    assign route_src   = {fc_tick, msel, fp_tick, ee_q[0]};

    for (genvar g = 0; g < N_ROUTE; g++) begin : g_route
        assign route_req[g] = eff[ROUTE_BIT[g]];
    end

    always_comb begin
        dout = 1'b0;
        for (int i = N_ROUTE - 1; i >= 0; i--) begin
            if (route_req[i]) dout = route_src[i];
        end
    end

    assign route_err = (route_req & (route_req - 1'b1)) != '0;

endmodule

// File: rtl/freq_reg_bank.sv
module freq_reg_bank
    import frb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              xfer_strobe,
    input  logic              enh_strobe,
    input  logic              nv_load,
    input  logic              nv_sel,
    input  logic              word_sel,
    input  logic              enh_en_n,
    input  logic [WORD_W-1:0] nv_word,
    input  logic              div_main_tick,
    input  logic              div_ref_tick,
    input  logic              mod_sel,
    output logic [R_W-1:0]    r_div,
    output logic [M_W-1:0]    m_div,
    output logic [A_W-1:0]    a_div,
    output logic              bypass,
    output logic              pwr_down,
    output logic              cnt_load,
    output logic              dout,
    output logic              route_err
);

    localparam int N_CTL = 8;

    logic [N_CTL-1:0] ctl_lvl, ctl_rise, ctl_fall;
    logic sclk_rise, data_s, xfer_s, xfer_rise, estb_s, enh_fall;
    logic nvld_s, nvld_fall, nvsel_s, nvsel_rise, fsel_s, enh_n_s;
    logic nv_par_load, readback_on;
    logic pri_shift, enh_shift, ee_shift;
    logic [WORD_W-1:0] pri_q, sec_q, ee_q;
    logic [ENH_W-1:0]  enh_buf;
    freq_fields_t      fields;

    frb_sync #(.WIDTH(N_CTL), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_clk, ser_data, xfer_strobe, enh_strobe,
                    nv_load, nv_sel, word_sel, enh_en_n}),
        .lvl      (ctl_lvl),
        .rise     (ctl_rise),
        .fall     (ctl_fall)
    );

    assign sclk_rise  = ctl_rise[7];
    assign data_s     = ctl_lvl[6];
    assign xfer_s     = ctl_lvl[5];
    assign xfer_rise  = ctl_rise[5];
    assign estb_s     = ctl_lvl[4];
    assign enh_fall   = ctl_fall[4];
    assign nvld_s     = ctl_lvl[3];
    assign nvld_fall  = ctl_fall[3];
    assign nvsel_s    = ctl_lvl[2];
    assign nvsel_rise = ctl_rise[2];
    assign fsel_s     = ctl_lvl[1];
    assign enh_n_s    = ctl_lvl[0];

    assign nv_par_load = (nvsel_rise && !nvld_s) || (nvld_fall && nvsel_s);

    frb_port u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise   (sclk_rise),
        .data_s      (data_s),
        .xfer_s      (xfer_s),
        .xfer_rise   (xfer_rise),
        .estb_s      (estb_s),
        .estb_fall   (enh_fall),
        .nvld_s      (nvld_s),
        .nv_par_load (nv_par_load),
        .readback_on (readback_on),
        .nv_word     (nv_word),
        .pri_shift   (pri_shift),
        .enh_shift   (enh_shift),
        .ee_shift    (ee_shift),
        .pri_q       (pri_q),
        .sec_q       (sec_q),
        .enh_buf     (enh_buf),
        .ee_q        (ee_q)
    );

    frb_route u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .nvsel_s     (nvsel_s),
        .fsel_s      (fsel_s),
        .nvld_s      (nvld_s),
        .enh_n_s     (enh_n_s),
        .pri_q       (pri_q),
        .sec_q       (sec_q),
        .ee_q        (ee_q),
        .enh_buf     (enh_buf),
        .fp_tick     (div_main_tick),
        .fc_tick     (div_ref_tick),
        .msel        (mod_sel),
        .fields      (fields),
        .pwr_down    (pwr_down),
        .cnt_load    (cnt_load),
        .readback_on (readback_on),
        .dout        (dout),
        .route_err   (route_err)
    );

    assign r_div  = fields.r;
    assign m_div  = fields.m;
    assign a_div  = fields.a;
    assign bypass = fields.pb;

endmodule

// File: rtl/frb_checker.sv
module frb_checker
    import frb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              data_s,
    input logic              pri_shift,
    input logic              enh_shift,
    input logic              xfer_rise,
    input logic              enh_fall,
    input logic              nv_par_load,
    input logic              enh_n_s,
    input logic [WORD_W-1:0] nv_word,
    input logic [WORD_W-1:0] pri_q,
    input logic [WORD_W-1:0] sec_q,
    input logic [WORD_W-1:0] ee_q,
    input logic [ENH_W-1:0]  enh_buf,
    input logic              pwr_down,
    input logic              cnt_load,
    input logic              route_err
);

    a_r1_pri_shift: assert property (@(posedge clk) disable iff (!rst_n)
        pri_shift |=> pri_q == {$past(data_s), $past(pri_q[WORD_W-1:1])});

    a_r2_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pri_shift, enh_shift}));

    a_r3_sec_copy: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_rise |=> sec_q == $past(pri_q));

    a_r3_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_rise |=> $stable(sec_q));

    a_r4_enh_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_fall |=> $stable(enh_buf));

    a_r7_par_load: assert property (@(posedge clk) disable iff (!rst_n)
        nv_par_load |=> ee_q == $past(nv_word));

    a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
        enh_n_s |-> (!pwr_down && !cnt_load && !route_err));

endmodule

bind freq_reg_bank frb_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_s      (data_s),
    .pri_shift   (pri_shift),
    .enh_shift   (enh_shift),
    .xfer_rise   (xfer_rise),
    .enh_fall    (enh_fall),
    .nv_par_load (nv_par_load),
    .enh_n_s     (enh_n_s),
    .nv_word     (nv_word),
    .pri_q       (pri_q),
    .sec_q       (sec_q),
    .ee_q        (ee_q),
    .enh_buf     (enh_buf),
    .pwr_down    (pwr_down),
    .cnt_load    (cnt_load),
    .route_err   (route_err)
);

// File: tb/freq_reg_bank_tb.sv
module freq_reg_bank_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 0, ser_data = 0, xfer_strobe = 0, enh_strobe = 0;
    logic nv_load = 0, nv_sel = 0, word_sel = 0, enh_en_n = 1;
    logic [19:0] nv_word = '0;
    logic div_main_tick = 0, div_ref_tick = 0, mod_sel = 0;
    logic [5:0] r_div;
    logic [8:0] m_div;
    logic [3:0] a_div;
    logic bypass, pwr_down, cnt_load, dout, route_err;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [19:0] m_pri = '0, m_sec = '0, m_ee = '0;
    logic [7:0]  m_esr = '0, m_ebuf = '0;

    always #5 clk = ~clk;

    freq_reg_bank u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .xfer_strobe(xfer_strobe), .enh_strobe(enh_strobe), .nv_load(nv_load),
        .nv_sel(nv_sel), .word_sel(word_sel), .enh_en_n(enh_en_n),
        .nv_word(nv_word), .div_main_tick(div_main_tick),
        .div_ref_tick(div_ref_tick), .mod_sel(mod_sel), .r_div(r_div),
        .m_div(m_div), .a_div(a_div), .bypass(bypass), .pwr_down(pwr_down),
        .cnt_load(cnt_load), .dout(dout), .route_err(route_err)
    );

    // Expected {r,m,a,pb} packed from the R8 layout
    function automatic logic [19:0] dec(input logic [19:0] w);
        logic [5:0] r;
        logic [8:0] m;
        logic [3:0] a;
        r = {w[0], w[1], w[12], w[13], w[14], w[15]};
        m = {w[2], w[3], w[5], w[6], w[7], w[8], w[9], w[10], w[11]};
        a = {w[16], w[17], w[18], w[19]};
        return {r, m, a, w[4]};
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] outw();
        return {r_div, m_div, a_div, bypass};
    endfunction

    // One serial bit; shadow models follow R1, R2 and R11
    task automatic sbit(input logic b);
        logic rb;
        rb = !enh_en_n && m_ebuf[1];
        ser_data = b;
        wait_cyc(4);
        ser_clk = 1'b1;
        wait_cyc(4);
        ser_clk = 1'b0;
        wait_cyc(4);
        if (!xfer_strobe && !enh_strobe && !nv_load) m_pri = {b, m_pri[19:1]};
        if (!xfer_strobe && enh_strobe && !nv_load) m_esr = {b, m_esr[7:1]};
        if ((!xfer_strobe && nv_load) || rb) m_ee = {b, m_ee[19:1]};
    endtask

    task automatic load_pri(input logic [19:0] w);
        for (int i = 0; i < 20; i++) sbit(w[i]);
    endtask

    task automatic load_enh(input logic [7:0] v);
        enh_strobe = 1'b1;
        wait_cyc(6);
        for (int i = 0; i < 8; i++) sbit(v[i]);
        enh_strobe = 1'b0;
        wait_cyc(6);
        m_ebuf = m_esr;
    endtask

    initial begin
        #1_500_000ns;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [19:0] w;
        logic [19:0] held;
        logic [7:0]  v;
        logic        exp_d;
        wait_cyc(10);
        rst_n = 1'b1;
        wait_cyc(6);

        // R12 reset state
        check("R12 fields", outw(), 20'h0);
        check("R12 pwr/cnt", {pwr_down, cnt_load}, 2'b00);
        check("R12 dout/err", {dout, route_err}, 2'b00);

        // R8 walking ones through the primary word, R5 primary selected
        word_sel = 1'b1;
        wait_cyc(6);
        for (int k = 0; k < 20; k++) begin
            load_pri(20'h1 << k);
            check($sformatf("R8 walk bit %0d", k), outw(), dec(20'h1 << k));
        end

        // R1 assorted words
        for (int k = 0; k < 6; k++) begin
            w = 20'((k + 1) * 32'h9E3B5) ^ 20'(k << 7);
            load_pri(w);
            check("R1 serial word", outw(), dec(m_pri));
        end

        // R6 unbuffered primary: each bit visible at once
        for (int k = 0; k < 5; k++) begin
            sbit(k[0] ^ 1'b1);
            check("R6 partial shift", outw(), dec(m_pri));
        end

        // R3 secondary holds until transfer strobe rises
        word_sel = 1'b0;
        wait_cyc(6);
        check("R3 secondary before copy", outw(), dec(m_sec));
        xfer_strobe = 1'b1;
        wait_cyc(6);
        m_sec = m_pri;
        // R2: shifts with transfer high reach no register
        held = m_pri;
        load_pri(20'hA5A5A);
        xfer_strobe = 1'b0;
        wait_cyc(6);
        check("R3 secondary after copy", outw(), dec(m_sec));
        word_sel = 1'b1;
        wait_cyc(6);
        check("R2 idle destination", outw(), dec(held));
        load_pri(20'h3C0F1);
        word_sel = 1'b0;
        wait_cyc(6);
        check("R3 secondary unchanged by shift", outw(), dec(m_sec));
        word_sel = 1'b1;
        wait_cyc(6);

        // R4 / R9 enhancement publication and gating
        enh_en_n = 1'b0;
        wait_cyc(6);
        enh_strobe = 1'b1;
        wait_cyc(6);
        for (int i = 0; i < 8; i++) sbit(i == 3);
        check("R4 not yet published", {pwr_down, cnt_load}, 2'b00);
        check("R2 enh shift leaves primary", outw(), dec(m_pri));
        enh_strobe = 1'b0;
        wait_cyc(6);
        m_ebuf = m_esr;
        check("R4/R9 power down published", {pwr_down, cnt_load}, 2'b10);
        enh_en_n = 1'b1;
        wait_cyc(6);
        check("R9 disabled", {pwr_down, cnt_load}, 2'b00);
        enh_en_n = 1'b0;
        wait_cyc(6);
        load_enh(8'h10);
        check("R9 counter load", {pwr_down, cnt_load}, 2'b01);

        // R10 route sweep: all route combinations against all tick patterns
        for (int c = 0; c < 16; c++) begin
            v = '0;
            v[1] = c[0];
            v[2] = c[1];
            v[5] = c[2];
            v[6] = c[3];
            load_enh(v);
            check($sformatf("R10 err c=%0d", c), route_err, $countones(c[3:0]) > 1);
            for (int p = 0; p < 8; p++) begin
                div_main_tick = p[0];
                mod_sel       = p[1];
                div_ref_tick  = p[2];
                wait_cyc(2);
                if (c[0])      exp_d = m_ee[0];
                else if (c[1]) exp_d = p[0];
                else if (c[2]) exp_d = p[1];
                else if (c[3]) exp_d = p[2];
                else           exp_d = 1'b0;
                check($sformatf("R10 dout c=%0d p=%0d", c, p), dout, exp_d);
            end
        end
        load_enh(8'h00);

        // R7 parallel loads, R5 source selection and hold
        nv_word = 20'h6D2B9;
        wait_cyc(2);
        nv_sel = 1'b1;
        wait_cyc(6);
        m_ee = nv_word;
        check("R7 rising select load", outw(), dec(m_ee));
        nv_word = 20'h1F0E3;
        wait_cyc(6);
        check("R7 no edge no load", outw(), dec(m_ee));
        nv_load = 1'b1;
        wait_cyc(6);
        nv_load = 1'b0;
        wait_cyc(6);
        m_ee = nv_word;
        check("R7 falling load with select", outw(), dec(m_ee));
        nv_load = 1'b1;
        wait_cyc(6);
        nv_sel = 1'b0;
        word_sel = 1'b1;
        wait_cyc(6);
        check("R5 hold while load high", outw(), dec(m_ee));
        nv_load = 1'b0;
        wait_cyc(6);
        check("R5 primary after release", outw(), dec(m_pri));

        // R11 serial load of stored word, then readback
        nv_load = 1'b1;
        wait_cyc(6);
        load_pri(20'hB4E27);
        nv_load = 1'b0;
        wait_cyc(6);
        held = m_ee;
        check("R2 stored word serial load", held, 20'hB4E27);
        load_enh(8'h02);
        check("R11 bit 0 before edges", dout, held[0]);
        for (int i = 1; i < 20; i++) begin
            sbit(1'b0);
            check($sformatf("R11 readback bit %0d", i), dout, held[i]);
        end
        check("R6 primary shifted alongside", outw(), dec(m_pri));

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule